// File: doc/BRIEF.md
# Frame Buffer Scan Address Generator

This block produces the stream of memory addresses a display controller reads while scanning out one frame of 16-bit pixels. Every pixel occupies one halfword, so each accepted fetch request steps a halfword counter by one. At the end of every visible line the counter also jumps over a programmable number of unused halfwords, so a narrow viewport can be scanned out of a wider virtual image. When the counter reaches a programmed end value, the block returns to the frame base and flags the end of the frame for one cycle.

The byte address is built from three parts. A constant bank field supplies the upper bits, the halfword counter supplies the middle bits, and the least significant bit is always zero. The counter wraps within its own width and never carries into the bank field. For this reason the whole buffer must lie inside one aligned bank-sized region (4 MB with the default widths). A start-of-frame pulse captures the whole configuration and restarts the scan. Between two such pulses, changes on the configuration inputs have no effect.

Top module: `fb_scan_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `addr_o` is zero and `eof_o` is low.
- R2: `addr_o` equals {1'b0, bank, counter, 1'b0}: bit 0 and bit 31 are always zero, bits 30:22 carry the captured bank and bits 21:1 carry the halfword counter.
- R3: A cycle with `sof_i` high loads the counter from `base_i` and captures bank, base, end, page width and line skip. From the next cycle `addr_o` shows the new base, and the line position restarts at pixel 0.
- R4: A cycle with `fetch_i` high and `sof_i` low that is not the last pixel of a line and does not reach the end value advances the counter by one. A cycle with neither `sof_i` nor `fetch_i` leaves `addr_o` unchanged.
- R5: The fetch of the page-width-th pixel of a line advances the counter by one plus the captured line skip.
- R6: When the advanced counter value equals the captured end value, the counter reloads the captured base and `eof_o` is high in the next cycle for one cycle. In every other cycle `eof_o` is low.
- R7: Changes on `bank_i`, `base_i`, `end_i`, `page_w_i` or `line_skip_i` while `sof_i` is low have no effect on `addr_o` or `eof_o`.
- R8: The halfword counter wraps modulo 2^21, and the bank bits of `addr_o` keep their captured value across that wrap.
- R9: When `sof_i` and `fetch_i` are high in the same cycle, the start of frame wins and the fetch is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sof_i | input | 1 | Start of frame: restart the scan and capture the configuration |
| fetch_i | input | 1 | One pixel fetch taken; advance to the next address |
| bank_i | input | 9 | Bank field, byte address bits 30:22 |
| base_i | input | 21 | Frame base, byte address bits 21:1 |
| end_i | input | 21 | Frame end value (last halfword address plus one) |
| page_w_i | input | 11 | Visible pixels per line, at least 1 |
| line_skip_i | input | 11 | Halfwords skipped after each visible line |
| addr_o | output | 32 | Byte address of the current pixel fetch |
| eof_o | output | 1 | One-cycle end-of-frame flag after the reload to base |

## Verification
The bench builds the block with its default widths: a 9-bit bank, a 21-bit halfword counter and 11-bit line fields. It programs page widths of three and four pixels and skips of zero and two, so line ends and frame ends fall every few cycles and several frames fit in a short run. A base placed a few halfwords below 2^21, with an end value that has already wrapped, brings the counter wrap into reach next to a bank of all ones. A start of frame in the middle of a frame, and one that coincides with a fetch, exercise the restart and its priority over the fetch.

// File: rtl/fb_scan_pkg.sv
// Shared types for the frame buffer scan address generator.
// Assumes: nothing beyond the standard language.
package fb_scan_pkg;

    // What the halfword counter does in the current cycle.
    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,   // no fetch, no restart
        STEP_PIXEL  = 2'd1,   // advance by one halfword
        STEP_SKIP   = 2'd2,   // last pixel of a line: advance by one plus skip
        STEP_RELOAD = 2'd3    // start of frame: load the base
    } step_e;

endpackage

// File: rtl/fb_cfg_regs.sv
// Configuration capture for the scan address generator.
// Captures bank, base, end, page width and line skip when a start of frame
// is seen, and holds them for the rest of the frame.
// Assumes: sof_i is a single-cycle pulse in the clk domain.
module fb_cfg_regs #(
    parameter int BANK_W = 9,
    parameter int CNT_W  = 21,
    parameter int PW_W   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [CNT_W-1:0]  base_i,
    input  logic [CNT_W-1:0]  end_i,
    input  logic [PW_W-1:0]   page_w_i,
    input  logic [PW_W-1:0]   line_skip_i,
    output logic [BANK_W-1:0] bank_q,
    output logic [CNT_W-1:0]  base_q,
    output logic [CNT_W-1:0]  end_q,
    output logic [PW_W-1:0]   page_w_q,
    output logic [PW_W-1:0]   skip_q
);

    // Capture the whole configuration at start of frame only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q   <= '0;
            base_q   <= '0;
            end_q    <= '0;
            page_w_q <= '0;
            skip_q   <= '0;
        end else if (sof_i) begin
            bank_q   <= bank_i;
            base_q   <= base_i;
            end_q    <= end_i;
            page_w_q <= page_w_i;
            skip_q   <= line_skip_i;
        end
    end

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_i |=> $stable(bank_q) && $stable(base_q) && $stable(end_q)
                   && $stable(page_w_q) && $stable(skip_q));

endmodule

// File: rtl/fb_line_pos.sv
// Line position tracker for the scan address generator.
// Counts the pixels fetched in the current line and classifies each cycle
// as hold, plain pixel step, end-of-line skip or frame restart.
// Assumes: page_w_q is at least 1 once a frame has been started.
module fb_line_pos
    import fb_scan_pkg::*;
#(
    parameter int PW_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sof_i,
    input  logic            fetch_i,
    input  logic            wrap_i,
    input  logic [PW_W-1:0] page_w_q,
    output step_e           step_o
);

    localparam logic [PW_W-1:0] ONE = PW_W'(1);

    logic [PW_W-1:0] col_q;
    logic            line_last;

    assign line_last = (col_q == page_w_q - ONE);

    // Classify the current cycle; restart beats any fetch.
    always_comb begin
        if (sof_i)        step_o = STEP_RELOAD;
        else if (!fetch_i) step_o = STEP_HOLD;
        else if (line_last) step_o = STEP_SKIP;
        else              step_o = STEP_PIXEL;
    end

    // Track the pixel index inside the current visible line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (sof_i || wrap_i) begin
            col_q <= '0;
        end else if (fetch_i) begin
            col_q <= line_last ? '0 : col_q + ONE;
        end
    end

    // R5
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_w_q != '0) |-> (col_q < page_w_q));

    // R9
    sof_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> (col_q == '0));

endmodule

// File: rtl/fb_addr_ctr.sv
// Halfword address counter for the scan address generator.
// Steps once per pixel, adds the line skip at each line end, reloads the
// base at the programmed end value and flags end of frame for one cycle.
// Assumes: the counter wraps within CNT_W bits; callers keep the buffer in
// one bank so no carry into the bank bits is needed.
module fb_addr_ctr
    import fb_scan_pkg::*;
#(
    parameter int CNT_W = 21,
    parameter int PW_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step_i,
    input  logic [CNT_W-1:0] base_i,
    input  logic [CNT_W-1:0] base_q,
    input  logic [CNT_W-1:0] end_q,
    input  logic [PW_W-1:0]  skip_q,
    output logic             wrap_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             eof_o
);

    localparam int PAD = CNT_W - PW_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] skip_ext;
    logic             eof_q;

    assign skip_ext = {{PAD{1'b0}}, skip_q};

    // Next counter value for a fetch, modulo 2^CNT_W.
    always_comb begin
        nxt = cnt_q + ONE;
        if (step_i == STEP_SKIP) nxt = cnt_q + ONE + skip_ext;
    end

    // A fetch that lands on the end value ends the frame.
    assign wrap_o = ((step_i == STEP_PIXEL) || (step_i == STEP_SKIP)) && (nxt == end_q);

    // Update the counter and the end-of-frame flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            eof_q <= 1'b0;
        end else begin
            eof_q <= wrap_o;
            case (step_i)
                STEP_RELOAD: cnt_q <= base_i;
                STEP_PIXEL,
                STEP_SKIP:   cnt_q <= wrap_o ? base_q : nxt;
                default:     cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o = cnt_q;
    assign eof_o = eof_q;

    // R3
    sof_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(step_i == STEP_RELOAD) |-> (cnt_q == $past(base_i)) && !eof_q);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_HOLD) |=> $stable(cnt_q) && !eof_q);

    // R6
    eof_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof_q |-> (cnt_q == base_q));

endmodule

// File: rtl/fb_scan_addr_gen.sv
// Frame buffer scan address generator, top level.
// Emits the byte address {0, bank, halfword counter, 0} of each pixel fetch
// of a 16-bit-per-pixel frame and a one-cycle end-of-frame flag.
// Assumes: the frame lies inside one aligned bank, page width >= 1, and the
// end value is reachable from the base with the programmed geometry.
module fb_scan_addr_gen
    import fb_scan_pkg::*;
#(
    parameter int BANK_W = 9,
    parameter int CNT_W  = 21,
    parameter int PW_W   = 11,
    localparam int ADDR_W = BANK_W + CNT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_i,
    input  logic              fetch_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [CNT_W-1:0]  base_i,
    input  logic [CNT_W-1:0]  end_i,
    input  logic [PW_W-1:0]   page_w_i,
    input  logic [PW_W-1:0]   line_skip_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              eof_o
);

    logic [BANK_W-1:0] bank_q;
    logic [CNT_W-1:0]  base_q;
    logic [CNT_W-1:0]  end_q;
    logic [PW_W-1:0]   page_w_q;
    logic [PW_W-1:0]   skip_q;
    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    step_e             step;

    fb_cfg_regs #(.BANK_W(BANK_W), .CNT_W(CNT_W), .PW_W(PW_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i),
        .bank_i(bank_i), .base_i(base_i), .end_i(end_i),
        .page_w_i(page_w_i), .line_skip_i(line_skip_i),
        .bank_q(bank_q), .base_q(base_q), .end_q(end_q),
        .page_w_q(page_w_q), .skip_q(skip_q)
    );

    fb_line_pos #(.PW_W(PW_W)) u_line (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .fetch_i(fetch_i),
        .wrap_i(wrap), .page_w_q(page_w_q), .step_o(step)
    );

    fb_addr_ctr #(.CNT_W(CNT_W), .PW_W(PW_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .step_i(step),
        .base_i(base_i), .base_q(base_q), .end_q(end_q), .skip_q(skip_q),
        .wrap_o(wrap), .cnt_o(cnt), .eof_o(eof_o)
    );

    // Compose the halfword-aligned byte address.
    assign addr_o = {1'b0, bank_q, cnt, 1'b0};

    // R2
    always_comb begin
        align_chk: assert (addr_o[0] == 1'b0 && addr_o[ADDR_W-1] == 1'b0);
    end

    // R8
    bank_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_i |=> (addr_o[ADDR_W-2 -: BANK_W] == $past(addr_o[ADDR_W-2 -: BANK_W])));

endmodule

// File: tb/sim_fb_scan_addr_gen.sv
module sim_fb_scan_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_i = 1'b0;
    logic        fetch_i = 1'b0;
    logic [8:0]  bank_i = '0;
    logic [20:0] base_i = '0;
    logic [20:0] end_i = '0;
    logic [10:0] page_w_i = '0;
    logic [10:0] line_skip_i = '0;
    logic [31:0] addr_o;
    logic        eof_o;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    int eof_seen = 0;

    // reference state
    longint m_cnt = 0, m_col = 0, m_bank = 0, m_base = 0, m_end = 0, m_pw = 0, m_off = 0;
    bit     m_eof = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    fb_scan_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .fetch_i(fetch_i),
        .bank_i(bank_i), .base_i(base_i), .end_i(end_i),
        .page_w_i(page_w_i), .line_skip_i(line_skip_i),
        .addr_o(addr_o), .eof_o(eof_o)
    );

    // Behavioural reference: one update per rising edge.
    always @(posedge clk) begin
        longint nxt;
        if (!rst_n) begin
            m_cnt = 0; m_col = 0; m_eof = 0;
            m_bank = 0; m_base = 0; m_end = 0; m_pw = 0; m_off = 0;
        end else if (sof_i) begin
            m_bank = bank_i; m_base = base_i; m_end = end_i;
            m_pw = page_w_i; m_off = line_skip_i;
            m_cnt = base_i; m_col = 0; m_eof = 0;
        end else if (fetch_i) begin
            if (m_col == m_pw - 1) begin
                nxt = m_cnt + 1 + m_off;
                m_col = 0;
            end else begin
                nxt = m_cnt + 1;
                m_col = m_col + 1;
            end
            nxt = nxt % (64'd1 << 21);
            if (nxt == m_end) begin
                m_cnt = m_base; m_col = 0; m_eof = 1;
            end else begin
                m_cnt = nxt; m_eof = 0;
            end
        end else begin
            m_eof = 0;
        end
    end

    function automatic logic [31:0] exp_addr();
        return {1'b0, m_bank[8:0], m_cnt[20:0], 1'b0};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare the outputs with the model, then drive the next inputs.
    task automatic step(bit s, bit f);
        @(negedge clk);
        check({cur_req, " addr"}, addr_o, exp_addr());
        check({cur_req, " eof"}, {31'd0, eof_o}, {31'd0, m_eof});
        if (eof_o) eof_seen++;
        sof_i = s;
        fetch_i = f;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual running expected done");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 addr in reset", addr_o, 32'h0);
        rst_n = 1'b1;
        step(0, 0);
        check("R1 eof after reset", {31'd0, eof_o}, 32'd0);

        // R3: start a frame, 4 pixels per line, skip 2, 3 lines
        cur_req = "R3";
        bank_i = 9'h1A5; base_i = 21'h000100; end_i = 21'h000112;
        page_w_i = 11'd4; line_skip_i = 11'd2;
        step(1, 0);
        step(0, 0);
        check("R3 base loaded", addr_o, {1'b0, 9'h1A5, 21'h000100, 1'b0});
        check("R2 bit0 and bit31 clear", {30'd0, addr_o[31], addr_o[0]}, 32'd0);

        // R4: single steps with gaps
        cur_req = "R4";
        step(0, 1);
        step(0, 0);
        check("R4 one halfword step", addr_o, {1'b0, 9'h1A5, 21'h000101, 1'b0});
        step(0, 0);
        check("R4 hold without fetch", addr_o, {1'b0, 9'h1A5, 21'h000101, 1'b0});

        // R5: finish the line; the skip of 2 lands on 0x106
        cur_req = "R5";
        step(0, 1); step(0, 1); step(0, 1);
        step(0, 0);
        check("R5 skip after line end", addr_o, {1'b0, 9'h1A5, 21'h000106, 1'b0});

        // R6: run the rest of this frame plus two more (8 + 24 fetches)
        cur_req = "R6";
        eof_seen = 0;
        for (int i = 0; i < 32; i++) step(0, 1);
        step(0, 0);
        step(0, 0);
        check("R6 eof pulse count", eof_seen, 32'd3);
        check("R6 back at base", addr_o, {1'b0, 9'h1A5, 21'h000100, 1'b0});

        // R7: change configuration without a start of frame
        cur_req = "R7";
        bank_i = 9'h055; base_i = 21'h0ABCDE; end_i = 21'h000105;
        page_w_i = 11'd7; line_skip_i = 11'd9;
        for (int i = 0; i < 30; i++) step(0, (i % 3) != 1);
        step(0, 0);
        check("R7 bank unchanged", {23'd0, addr_o[30:22]}, {23'd0, 9'h1A5});

        // R3: restart in the middle of a frame with random fetches
        cur_req = "R3";
        bank_i = 9'h0F0; base_i = 21'h012340; end_i = 21'h012340 + 21'd15;
        page_w_i = 11'd3; line_skip_i = 11'd2;
        step(1, 0);
        for (int i = 0; i < 60; i++) step(0, 1'($urandom_range(0, 1)));

        // R9: restart together with a fetch; base just below the counter wrap
        cur_req = "R9";
        bank_i = 9'h1FF; base_i = 21'h1FFFFC; end_i = 21'h000008;
        page_w_i = 11'd3; line_skip_i = 11'd0;
        step(1, 1);
        step(0, 0);
        check("R9 sof beats fetch", addr_o, {1'b0, 9'h1FF, 21'h1FFFFC, 1'b0});

        // R8: cross the 2^21 boundary, bank must stay all ones
        cur_req = "R8";
        for (int i = 0; i < 5; i++) step(0, 1);
        step(0, 0);
        check("R8 counter wrapped", addr_o, {1'b0, 9'h1FF, 21'h000001, 1'b0});
        check("R8 no carry to bit31", {31'd0, addr_o[31]}, 32'd0);
        eof_seen = 0;
        for (int i = 0; i < 40; i++) step(0, 1'($urandom_range(0, 3) != 0));
        step(0, 0);
        step(0, 0);
        check("R8 bank kept", {23'd0, addr_o[30:22]}, {23'd0, 9'h1FF});

        summary();
    end

endmodule